// File: doc/BRIEF.md
# Status Byte and Service Request Unit

This unit assembles an 8-bit status byte from seven level summary signals that other status structures drive: operation summary, event summary, message available, questionable summary, error queue not empty, list running and busy. None of these levels is stored here, so each status bit follows its source and clears only when that source clears. A software-writable 8-bit enable register selects which of those bits may call for service.

The enabled bits are ANDed with the status bits and ORed into a master summary. A 0-to-1 transition of the master summary latches a request-for-service flag, which drives the `srq` output. The flag is held until a serial poll or a reset, even if the master summary falls again. Bit 6 of the status byte is not stored. A status query shows the live master summary there and clears nothing. A serial poll shows the latched request flag there and clears it.

The request flag is a two-state machine. The states are `RQ_IDLE` (no request pending) and `RQ_PENDING` (request latched, `srq` high). The transitions are:
- `SET`: from `RQ_IDLE` to `RQ_PENDING` when the master summary rises.
- `POLL_CLEAR`: from `RQ_PENDING` to `RQ_IDLE` on a serial poll with no simultaneous rise.
- `HOLD`: stay in the current state otherwise. A rise in `RQ_PENDING`, including one that coincides with a poll, keeps the state in `RQ_PENDING`.

Accesses use `acc_valid` together with `acc_kind`:
- `2'b00`: enable write.
- `2'b01`: enable read.
- `2'b10`: status query.
- `2'b11`: serial poll.

Top module: `stb_srq_core`

## Requirements
- R1: Status query and serial poll return the live sources in bit 7 (operation summary), bit 5 (event summary), bit 4 (message available), bit 3 (questionable summary), bit 2 (error queue not empty), bit 1 (list running) and bit 0 (busy).
- R2: An enable write (`acc_kind` 2'b00) stores `acc_wdata` with bit 6 forced to 0. An enable read (`acc_kind` 2'b01) returns exactly that value, with bit 6 = 0.
- R3: The master summary is the OR, over bits 0 to 5 and 7, of status bit AND enable bit. A status query (`acc_kind` 2'b10) returns it in bit 6.
- R4: A status query clears nothing: `srq` and the enable register are unchanged after it.
- R5: A 0-to-1 transition of the master summary moves the machine to `RQ_PENDING` at the next clock edge, and `srq` goes high. `srq` stays high when the master summary later falls.
- R6: A serial poll (`acc_kind` 2'b11) returns the request flag in bit 6 as it was before the poll, and clears it (`srq` low after the poll edge).
- R7: When a master-summary rise coincides with a serial poll, the set wins: `srq` remains high and the next poll still reports the request.
- R8: Reset (`rst_n` low) clears the enable register, the request flag and `rd_valid`.
- R9: `rd_data` and `rd_valid` are registered. `rd_valid` is high for exactly the cycle after a read-type access (2'b01, 2'b10, 2'b11), and low after an enable write or an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| oper_sum | input | 1 | Operation status summary level |
| evt_sum | input | 1 | Event status summary level |
| msg_avail | input | 1 | Message available level |
| ques_sum | input | 1 | Questionable status summary level |
| err_pending | input | 1 | Error queue not empty level |
| list_run | input | 1 | List running level |
| busy | input | 1 | Busy level |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_kind | input | 2 | Access type: 00 write enable, 01 read enable, 10 status query, 11 serial poll |
| acc_wdata | input | 8 | Enable write data |
| rd_data | output | 8 | Read result, registered |
| rd_valid | output | 1 | Read result valid for one cycle |
| srq | output | 1 | Service request, high while a request is pending |

## Verification
The bench builds the unit with its default parameters: an 8-bit byte with the request bit at position 6. This is the only layout in which the status-bit positions of R1 have meaning. With these values, one vector table can walk every source bit against enable masks that cover and miss it. The same table reaches the masked bit 6 and the enable-readback path. Directed sequences then reach the sticky request after the summary falls, the poll-versus-query difference in bit 6, the same-edge set-and-clear race, and reset in the middle of operation.

// File: rtl/stb_pkg.sv
package stb_pkg;

    localparam int STB_W   = 8;
    localparam int RQS_POS = 6;

    localparam int POS_OPER = 7;
    localparam int POS_EVT  = 5;
    localparam int POS_MAV  = 4;
    localparam int POS_QUES = 3;
    localparam int POS_ERR  = 2;
    localparam int POS_LIST = 1;
    localparam int POS_BUSY = 0;

    typedef enum logic [1:0] {
        ACC_EN_WR  = 2'b00,
        ACC_EN_RD  = 2'b01,
        ACC_STB_RD = 2'b10,
        ACC_POLL   = 2'b11
    } acc_kind_e;

    typedef enum logic {
        RQ_IDLE    = 1'b0,
        RQ_PENDING = 1'b1
    } rq_state_e;

endpackage

// File: rtl/stb_enable_reg.sv
module stb_enable_reg #(
    parameter int W       = 8,
    parameter int HOLE    = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] en_q
);
    localparam logic [W-1:0] HOLE_MASK = W'(1) << HOLE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en) begin
            en_q <= wr_data & ~HOLE_MASK;
        end
    end
endmodule

// File: rtl/stb_summary.sv
module stb_summary #(
    parameter int W    = 8,
    parameter int HOLE = 6
) (
    input  logic [W-1:0] stat,
    input  logic [W-1:0] en,
    output logic         mss
);
    logic [W-1:0] term;

    generate
        for (genvar i = 0; i < W; i++) begin : g_term
            if (i == HOLE) begin : g_hole
                assign term[i] = 1'b0;
            end else begin : g_bit
                assign term[i] = stat[i] & en[i];
            end
        end
    endgenerate

    assign mss = |term;
endmodule

// File: rtl/stb_request_fsm.sv
module stb_request_fsm
    import stb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mss,
    input  logic poll,
    output logic rqs
);
    rq_state_e state_q, state_d;
    logic      mss_q;
    logic      rise;

    assign rise = mss & ~mss_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RQ_IDLE;
            mss_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            mss_q   <= mss;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RQ_IDLE: begin
                if (rise) state_d = RQ_PENDING;
            end
            RQ_PENDING: begin
                if (poll && !rise) state_d = RQ_IDLE;
            end
            default: state_d = RQ_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RQ_PENDING: rqs = 1'b1;
            default:    rqs = 1'b0;
        endcase
    end
endmodule

// File: rtl/stb_read_port.sv
module stb_read_port
    import stb_pkg::*;
#(
    parameter int W    = 8,
    parameter int HOLE = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         acc_valid,
    input  acc_kind_e    kind,
    input  logic [W-1:0] en,
    input  logic [W-1:0] stat,
    input  logic         mss,
    input  logic         rqs,
    output logic [W-1:0] rd_data,
    output logic         rd_valid
);
    localparam logic [W-1:0] HOLE_MASK = W'(1) << HOLE;

    logic [W-1:0] data_d;
    logic         valid_d;

    always_comb begin
        data_d  = rd_data;
        valid_d = 1'b0;
        if (acc_valid) begin
            unique case (kind)
                ACC_EN_WR: begin
                    valid_d = 1'b0;
                end
                ACC_EN_RD: begin
                    data_d  = en & ~HOLE_MASK;
                    valid_d = 1'b1;
                end
                ACC_STB_RD: begin
                    data_d  = (stat & ~HOLE_MASK) | (mss ? HOLE_MASK : '0);
                    valid_d = 1'b1;
                end
                ACC_POLL: begin
                    data_d  = (stat & ~HOLE_MASK) | (rqs ? HOLE_MASK : '0);
                    valid_d = 1'b1;
                end
                default: valid_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_data  <= data_d;
            rd_valid <= valid_d;
        end
    end
endmodule

// File: rtl/stb_srq_core.sv
module stb_srq_core
    import stb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             oper_sum,
    input  logic             evt_sum,
    input  logic             msg_avail,
    input  logic             ques_sum,
    input  logic             err_pending,
    input  logic             list_run,
    input  logic             busy,
    input  logic             acc_valid,
    input  logic [1:0]       acc_kind,
    input  logic [STB_W-1:0] acc_wdata,
    output logic [STB_W-1:0] rd_data,
    output logic             rd_valid,
    output logic             srq
);
    acc_kind_e        kind;
    logic [STB_W-1:0] stat_w;
    logic [STB_W-1:0] en_w;
    logic             mss_w;
    logic             rqs_w;
    logic             wr_w;
    logic             poll_w;

    assign kind   = acc_kind_e'(acc_kind);
    assign wr_w   = acc_valid && (kind == ACC_EN_WR);
    assign poll_w = acc_valid && (kind == ACC_POLL);

    always_comb begin
        stat_w           = '0;
        stat_w[POS_OPER] = oper_sum;
        stat_w[POS_EVT]  = evt_sum;
        stat_w[POS_MAV]  = msg_avail;
        stat_w[POS_QUES] = ques_sum;
        stat_w[POS_ERR]  = err_pending;
        stat_w[POS_LIST] = list_run;
        stat_w[POS_BUSY] = busy;
    end

    stb_enable_reg #(.W(STB_W), .HOLE(RQS_POS)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_w),
        .wr_data (acc_wdata),
        .en_q    (en_w)
    );

    stb_summary #(.W(STB_W), .HOLE(RQS_POS)) u_sum (
        .stat (stat_w),
        .en   (en_w),
        .mss  (mss_w)
    );

    stb_request_fsm u_rq (
        .clk   (clk),
        .rst_n (rst_n),
        .mss   (mss_w),
        .poll  (poll_w),
        .rqs   (rqs_w)
    );

    stb_read_port #(.W(STB_W), .HOLE(RQS_POS)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .kind      (kind),
        .en        (en_w),
        .stat      (stat_w),
        .mss       (mss_w),
        .rqs       (rqs_w),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

    assign srq = rqs_w;
endmodule

// File: rtl/stb_srq_core_chk.sv
module stb_srq_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_valid,
    input logic [1:0] acc_kind,
    input logic [7:0] rd_data,
    input logic       rd_valid,
    input logic       srq,
    input logic       mss
);
    logic poll_c;
    logic query_c;
    assign poll_c  = acc_valid && (acc_kind == 2'b11);
    assign query_c = acc_valid && (acc_kind == 2'b10);

    AST_EN_RD_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'b01) |=> (rd_valid && !rd_data[6])); // R2

    AST_QUERY_MSS: assert property (@(posedge clk) disable iff (!rst_n)
        query_c |=> (rd_data[6] == $past(mss))); // R3

    AST_QUERY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (query_c && srq) |=> srq); // R4

    AST_SET_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mss) |=> srq); // R5

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (srq && !poll_c) |=> srq); // R5

    AST_POLL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_c && !$rose(mss)) |=> !srq); // R6

    AST_POLL_REPORTS: assert property (@(posedge clk) disable iff (!rst_n)
        poll_c |=> (rd_data[6] == $past(srq))); // R6

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_c && $rose(mss)) |=> srq); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!srq && !rd_valid)); // R8

    AST_WR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'b00) |=> !rd_valid); // R9
endmodule

bind stb_srq_core stb_srq_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_kind  (acc_kind),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .srq       (srq),
    .mss       (mss_w)
);

// File: tb/stb_srq_core_test.sv
module stb_srq_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oper_sum = 0, evt_sum = 0, msg_avail = 0, ques_sum = 0;
    logic       err_pending = 0, list_run = 0, busy = 0;
    logic       acc_valid = 0;
    logic [1:0] acc_kind = 2'b00;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] rd_data;
    logic       rd_valid;
    logic       srq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    stb_srq_core uut (
        .clk(clk), .rst_n(rst_n),
        .oper_sum(oper_sum), .evt_sum(evt_sum), .msg_avail(msg_avail),
        .ques_sum(ques_sum), .err_pending(err_pending), .list_run(list_run),
        .busy(busy), .acc_valid(acc_valid), .acc_kind(acc_kind),
        .acc_wdata(acc_wdata), .rd_data(rd_data), .rd_valid(rd_valid),
        .srq(srq)
    );

    // {source byte, enable written, expected status query}
    localparam logic [23:0] VEC [8] = '{
        {8'h00, 8'hFF, 8'h00},
        {8'h81, 8'h01, 8'hC1},
        {8'h3F, 8'h80, 8'h3F},
        {8'h10, 8'h10, 8'h50},
        {8'hA4, 8'h5B, 8'hA4},
        {8'h20, 8'h60, 8'h60},
        {8'h04, 8'h04, 8'h44},
        {8'h02, 8'hFD, 8'h02}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_src(input logic [7:0] s);
        @(negedge clk);
        oper_sum    = s[7];
        evt_sum     = s[5];
        msg_avail   = s[4];
        ques_sum    = s[3];
        err_pending = s[2];
        list_run    = s[1];
        busy        = s[0];
    endtask

    task automatic access(input logic [1:0] k, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_kind  = k;
        acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_fail++;
                n_checks++;
                $display("FAIL watchdog actual=%0d expected<=20000", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        idle(3);
        // R8: reset state
        check("R8 srq", {7'd0, srq}, 8'h00);
        check("R8 rd_valid", {7'd0, rd_valid}, 8'h00);
        rst_n = 1'b1;
        access(2'b01, 8'h00);
        check("R8 enable", rd_data, 8'h00);
        check("R9 valid after read", {7'd0, rd_valid}, 8'h01);

        // vector table: R1, R2, R3, R9
        for (int v = 0; v < 8; v++) begin
            set_src(VEC[v][23:16]);
            access(2'b00, VEC[v][15:8]);
            check("R9 no valid after write", {7'd0, rd_valid}, 8'h00);
            access(2'b01, 8'h00);
            check("R2 enable readback", rd_data, VEC[v][15:8] & 8'hBF);
            access(2'b10, 8'h00);
            check("R1 R3 status query", rd_data, VEC[v][7:0]);
        end
        idle(2);
        check("R9 idle no valid", {7'd0, rd_valid}, 8'h00);

        // clear any request left by the table
        set_src(8'h00);
        access(2'b11, 8'h00);
        idle(2);
        check("R6 cleared before directed", {7'd0, srq}, 8'h00);

        // R2: bit 6 cannot be written
        access(2'b00, 8'hFF);
        access(2'b01, 8'h00);
        check("R2 hole", rd_data, 8'hBF);

        // R5: set on rise, sticky after fall
        access(2'b00, 8'h10);
        set_src(8'h10);
        @(negedge clk);
        check("R5 set", {7'd0, srq}, 8'h01);
        set_src(8'h00);
        idle(3);
        check("R5 sticky", {7'd0, srq}, 8'h01);

        // R4: query clears nothing
        access(2'b10, 8'h00);
        check("R4 query mss low", rd_data, 8'h00);
        access(2'b10, 8'h00);
        check("R4 srq kept", {7'd0, srq}, 8'h01);
        access(2'b01, 8'h00);
        check("R4 enable kept", rd_data, 8'h10);

        // R6: poll reports and clears
        access(2'b11, 8'h00);
        check("R6 poll bit6", rd_data, 8'h40);
        check("R6 cleared", {7'd0, srq}, 8'h00);

        // R7: rise coincides with poll
        set_src(8'h10);
        idle(2);
        set_src(8'h00);
        idle(3);
        check("R7 pre srq", {7'd0, srq}, 8'h01);
        @(negedge clk);
        msg_avail = 1'b1;
        acc_valid = 1'b1;
        acc_kind  = 2'b11;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R7 poll data", rd_data, 8'h50);
        check("R7 set wins", {7'd0, srq}, 8'h01);
        access(2'b11, 8'h00);
        check("R7 later poll", rd_data, 8'h50);
        check("R6 cleared again", {7'd0, srq}, 8'h00);
        access(2'b11, 8'h00);
        check("R6 poll shows request not mss", rd_data, 8'h10);
        access(2'b10, 8'h00);
        check("R3 query shows mss", rd_data, 8'h50);

        // R8: reset mid-operation
        access(2'b00, 8'h00);
        set_src(8'h00);
        access(2'b00, 8'h10);
        set_src(8'h10);
        @(negedge clk);
        check("R5 set before reset", {7'd0, srq}, 8'h01);
        rst_n = 1'b0;
        idle(2);
        check("R8 srq after reset", {7'd0, srq}, 8'h00);
        rst_n = 1'b1;
        access(2'b01, 8'h00);
        check("R8 enable after reset", rd_data, 8'h00);
        idle(2);
        check("R8 no request after reset", {7'd0, srq}, 8'h00);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule